// File: doc/BRIEF.md
# Two-Button Clock Set Controller

This block turns two active-low push-button contacts into the adjustment events of a clock. One button advances the hour and the other advances the minute. Each contact is synchronised and debounced before it is used. A press gives one advance strobe at once. If the button stays held, one more strobe follows each second until it is released.

Holding both buttons together suppresses the advance strobes and raises a request to light every display segment. When the pair is released, the block issues a single display-clear pulse, unless the clear-permit input is low. A set-enable input must be high for the buttons to have any effect.

A fast mode, selected by driving the normal-mode input low, shortens every timing by a factor of 64. All timings come from one shared tick: in normal mode the tick fires once every SCALE clocks, and in fast mode it fires on every clock. The debounce time and the one-second interval are parameters counted in ticks.

Top module: `set_button_ctrl`

## Requirements
- R1: A button pin reads logic 0 when pressed and logic 1 when released. With both pins high, no output is ever active.
- R2: While set_en is low, both buttons are ignored: adv_hour, adv_min, seg_all_on and disp_clr all stay low.
- R3: An accepted press of the hour button alone gives exactly one single-cycle adv_hour strobe at once.
- R4: While the hour button stays held, one further adv_hour strobe follows each second, with the first one one second after the press. A hold of k and a half seconds gives k+1 strobes in total.
- R5: The minute button behaves as in R3 and R4, but its strobes appear on adv_min.
- R6: A change of level on a pin is accepted only after it has been stable for DEB_TICKS ticks. A shorter low pulse gives no strobe, and a shorter high pulse during a hold does not count as a release.
- R7: While both buttons are accepted as held, seg_all_on is high and neither advance strobe is produced. A strobe given to the first button before the second joined is kept, and its auto-repeat is cancelled.
- R8: When both buttons have been released after a two-button hold, and clr_permit is high, disp_clr pulses for exactly one cycle, in the cycle where seg_all_on falls.
- R9: If clr_permit is low when the two-button hold ends, no disp_clr pulse is produced.
- R10: With norm_mode low, the tick fires on every clock instead of every SCALE clocks (default 64). The debounce time, the repeat delay and the repeat period all become 64 times shorter.
- R11: adv_hour and adv_min are never high in the same cycle, and neither is ever high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_hr_n | input | 1 | Hour button, low when pressed |
| btn_min_n | input | 1 | Minute button, low when pressed |
| set_en | input | 1 | High enables the buttons |
| norm_mode | input | 1 | High selects normal timing, low selects 64x faster timing |
| clr_permit | input | 1 | Low suppresses the clear that follows a two-button hold |
| adv_hour | output | 1 | Single-cycle hour advance strobe |
| adv_min | output | 1 | Single-cycle minute advance strobe |
| seg_all_on | output | 1 | High while both buttons are held |
| disp_clr | output | 1 | Single-cycle display clear pulse |

## Verification
Each button is held alone for 0.5, 1.5, 2.5 and 3.5 seconds, in both normal and fast mode, and the strobes on each output are counted. This sweep tells a correct repeat delay and period apart from one that is off by a tick, and it shows whether a button's strobes leak onto the wrong output. Two-button holds are tried with a simultaneous press, with the hour button first and with the minute button first, each under both values of clr_permit. These runs separate the cancellation of a single-button repeat from the clear behaviour. Short glitches on press and on release, and holds made with set_en low, show that the filter and the gate reject what they should.

// File: rtl/setbtn_pkg.sv
package setbtn_pkg;
  typedef enum logic {
    MODE_IDLE  = 1'b0,
    MODE_COMBO = 1'b1
  } combo_state_t;
endpackage

// File: rtl/sbc_tick_gen.sv
module sbc_tick_gen #(
  parameter int unsigned SCALE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic norm_mode,
  output logic tick
);
  localparam int unsigned CW = $clog2(SCALE + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(SCALE - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = !norm_mode || wrap;
endmodule

// File: rtl/sbc_debounce.sv
module sbc_debounce #(
  parameter int unsigned DEB_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  output logic pressed
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);

  logic [1:0]    sync_q;
  logic          samp;
  logic          db_q, db_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign samp = ~sync_q[1];

  always_comb begin
    db_d  = db_q;
    cnt_d = '0;
    if (samp != db_q) begin
      cnt_d = cnt_q;
      if (tick) begin
        if (cnt_q == CW'(DEB_TICKS - 1)) begin
          db_d  = samp;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      db_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      db_q   <= db_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pressed = db_q;
endmodule

// File: rtl/sbc_repeat.sv
module sbc_repeat #(
  parameter int unsigned SEC_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic act,
  output logic strobe
);
  localparam int unsigned CW = $clog2(SEC_TICKS + 1);

  logic          act_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stb_q, stb_d;
  logic          due;

  assign due = act && act_q && tick && (cnt_q == CW'(SEC_TICKS - 1));

  always_comb begin
    stb_d = (act && !act_q) || due;
    if (!act || !act_q) cnt_d = '0;
    else if (tick)      cnt_d = due ? '0 : cnt_q + 1'b1;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      act_q <= act;
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign strobe = stb_q;
endmodule

// File: rtl/set_button_ctrl.sv
module set_button_ctrl
  import setbtn_pkg::*;
#(
  parameter int unsigned SCALE     = 64,
  parameter int unsigned DEB_TICKS = 8,
  parameter int unsigned SEC_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_hr_n,
  input  logic btn_min_n,
  input  logic set_en,
  input  logic norm_mode,
  input  logic clr_permit,
  output logic adv_hour,
  output logic adv_min,
  output logic seg_all_on,
  output logic disp_clr
);
  localparam int unsigned NBTN = 2;

  logic            tick;
  logic [NBTN-1:0] pins_n;
  logic [NBTN-1:0] held;
  logic [NBTN-1:0] live;
  logic [NBTN-1:0] act;
  logic [NBTN-1:0] stb;
  logic            both;
  logic            none;
  combo_state_t    st_q, st_d;
  logic            clr_q, clr_d;

  assign pins_n = {btn_min_n, btn_hr_n};

  sbc_tick_gen #(.SCALE(SCALE)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .norm_mode (norm_mode),
    .tick      (tick)
  );

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    sbc_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .pin_n   (pins_n[i]),
      .pressed (held[i])
    );

    assign live[i] = held[i] && set_en;
    assign act[i]  = live[i] && !both && (st_q == MODE_IDLE);

    sbc_repeat #(.SEC_TICKS(SEC_TICKS)) u_rep (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .act    (act[i]),
      .strobe (stb[i])
    );
  end

  assign both = &live;
  assign none = ~|live;

  always_comb begin
    st_d  = st_q;
    clr_d = 1'b0;
    case (st_q)
      MODE_IDLE:  if (both) st_d = MODE_COMBO;
      MODE_COMBO: if (none) begin
        st_d  = MODE_IDLE;
        clr_d = clr_permit;
      end
      default:    st_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= MODE_IDLE;
      clr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
    end
  end

  assign adv_hour   = stb[0];
  assign adv_min    = stb[1];
  assign seg_all_on = (st_q == MODE_COMBO);
  assign disp_clr   = clr_q;
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_permit,
  input logic adv_hour,
  input logic adv_min,
  input logic seg_all_on,
  input logic disp_clr
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv_hour && adv_min));

  // R11
  hour_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_hour |=> !adv_hour);

  // R11
  min_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_min |=> !adv_min);

  // R7
  combo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_all_on |-> (!adv_hour && !adv_min));

  // R8
  clr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_clr |-> (!seg_all_on && $past(seg_all_on)));

  // R9
  clr_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seg_all_on) |-> (disp_clr == $past(clr_permit)));

  // R8
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_clr |=> !disp_clr);
endmodule

bind set_button_ctrl sbc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_permit (clr_permit),
  .adv_hour   (adv_hour),
  .adv_min    (adv_min),
  .seg_all_on (seg_all_on),
  .disp_clr   (disp_clr)
);

// File: tb/set_button_ctrl_tb.sv
`timescale 1ns/1ps
module set_button_ctrl_tb;
  localparam int SCALE = 64;
  localparam int DEB   = 2;
  localparam int SEC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_hr_n = 1'b1, btn_min_n = 1'b1;
  logic set_en = 1'b1, norm_mode = 1'b1, clr_permit = 1'b1;
  logic adv_hour, adv_min, seg_all_on, disp_clr;

  always #10 clk = ~clk;

  set_button_ctrl #(.SCALE(SCALE), .DEB_TICKS(DEB), .SEC_TICKS(SEC)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_hr_n(btn_hr_n), .btn_min_n(btn_min_n),
    .set_en(set_en), .norm_mode(norm_mode), .clr_permit(clr_permit),
    .adv_hour(adv_hour), .adv_min(adv_min), .seg_all_on(seg_all_on),
    .disp_clr(disp_clr)
  );

  int checks = 0, failures = 0;
  int n_hr = 0, n_min = 0, n_clr = 0, n_seg = 0, n_bad = 0;
  logic p_hr = 0, p_min = 0, p_clr = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adv_hour) n_hr++;
      if (adv_min) n_min++;
      if (disp_clr) n_clr++;
      if (seg_all_on) n_seg++;
      if ((adv_hour && adv_min) || (adv_hour && p_hr) || (adv_min && p_min) || (disp_clr && p_clr))
        n_bad++;
    end
    p_hr = adv_hour; p_min = adv_min; p_clr = disp_clr;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sec_cyc();
    return norm_mode ? SEC * SCALE : SEC;
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cnt();
    n_hr = 0; n_min = 0; n_clr = 0; n_seg = 0; n_bad = 0;
  endtask

  task automatic settle();
    waitc(2 * sec_cyc() + 8);
  endtask

  // R3 R4 R5 R10: single-button hold of k+0.5 seconds gives k+1 strobes
  task automatic run_single(input bit nm, input bit which, input int k);
    norm_mode = nm; settle(); clear_cnt();
    if (which) btn_min_n = 1'b0; else btn_hr_n = 1'b0;
    waitc(k * sec_cyc() + sec_cyc() / 2);
    btn_hr_n = 1'b1; btn_min_n = 1'b1;
    settle();
    if (which) begin
      chk(nm ? "R5 minute count" : "R10 fast minute count", n_min, k + 1);
      chk("R5 no hour leak", n_hr, 0);
    end else begin
      chk(nm ? "R4 hour count" : "R10 fast hour count", n_hr, k + 1);
      chk("R3 no minute leak", n_min, 0);
    end
    chk("R11 strobe shape", n_bad, 0);
  endtask

  // R7 R8 R9: two-button hold, order 0 simultaneous, 1 hour first, 2 minute first
  task automatic run_combo(input bit nm, input int order, input bit permit);
    norm_mode = nm; clr_permit = permit; settle(); clear_cnt();
    if (order == 1) begin btn_hr_n = 1'b0; waitc(sec_cyc() / 2); end
    if (order == 2) begin btn_min_n = 1'b0; waitc(sec_cyc() / 2); end
    btn_hr_n = 1'b0; btn_min_n = 1'b0;
    waitc(2 * sec_cyc() + sec_cyc() / 2);
    chk("R7 seg_all_on while held", int'(seg_all_on), 1);
    btn_hr_n = 1'b1; btn_min_n = 1'b1;
    settle();
    chk("R7 hour strobes", n_hr, (order == 1) ? 1 : 0);
    chk("R7 minute strobes", n_min, (order == 2) ? 1 : 0);
    chk(permit ? "R8 clear count" : "R9 clear suppressed", n_clr, permit ? 1 : 0);
    chk("R8 seg_all_on cleared", int'(seg_all_on), 0);
    chk("R8 pulse shape", n_bad, 0);
    clr_permit = 1'b1;
  endtask

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(400);
    // R1: idle pins give nothing
    chk("R1 idle hour", n_hr, 0);
    chk("R1 idle minute", n_min, 0);
    chk("R1 idle seg", n_seg + n_clr, 0);

    for (int nm = 1; nm >= 0; nm--)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++)
          run_single(nm[0], w[0], k);

    for (int nm = 1; nm >= 0; nm--)
      for (int o = 0; o < 3; o++)
        for (int p = 0; p < 2; p++)
          run_combo(nm[0], o, p[0]);

    // R2: enable low
    norm_mode = 1'b1; set_en = 1'b0; settle(); clear_cnt();
    btn_hr_n = 1'b0; waitc(5 * sec_cyc() / 2); btn_hr_n = 1'b1; settle();
    btn_min_n = 1'b0; waitc(5 * sec_cyc() / 2); btn_min_n = 1'b1; settle();
    btn_hr_n = 1'b0; btn_min_n = 1'b0; waitc(2 * sec_cyc());
    btn_hr_n = 1'b1; btn_min_n = 1'b1; settle();
    chk("R2 disabled strobes", n_hr + n_min, 0);
    chk("R2 disabled seg/clr", n_seg + n_clr, 0);
    set_en = 1'b1;

    // R6: press glitches, normal (40 clocks) and fast (1 clock)
    settle(); clear_cnt();
    btn_hr_n = 1'b0; waitc(40); btn_hr_n = 1'b1; settle();
    chk("R6 normal press glitch", n_hr, 0);
    norm_mode = 1'b0; settle(); clear_cnt();
    btn_min_n = 1'b0; waitc(1); btn_min_n = 1'b1; settle();
    chk("R6 fast press glitch", n_min, 0);

    // R6: release glitch during a 2.5 s hold
    norm_mode = 1'b1; settle(); clear_cnt();
    btn_hr_n = 1'b0; waitc(sec_cyc() + sec_cyc() / 4);
    btn_hr_n = 1'b1; waitc(40); btn_hr_n = 1'b0;
    waitc(sec_cyc() + sec_cyc() / 4 - 40);
    btn_hr_n = 1'b1; settle();
    chk("R6 release glitch ignored", n_hr, 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule